// File: doc/BRIEF.md
# Block Address Translation Cache

This block maps large, fixed 512 KB regions of a 32-bit virtual address space onto physical memory. It holds a small set of block descriptors and compares every one of them, in parallel, against the incoming virtual address and the current privilege mode. It returns one of three results in the same cycle: a hit with the translated physical address and a read-only flag, a write-protection fault, or a miss. On a miss, the page-granular translation stage further down the pipe is consulted next.

Descriptors are loaded one at a time through a plain register write port that carries an entry index. The lookup side is a request stream with only a valid qualifier. The block accepts every request in the cycle it is presented and never applies back-pressure, so it has no ready output. Exactly one result strobe answers each valid request, in that same cycle. No strobe is raised while the request valid input is low.

Descriptor layout, 32 bits:
- bits [31:19] virtual block tag
- bits [18:6] physical block number
- bits [5:3] unused
- bit 2 supervisor-only
- bit 1 write-protect
- bit 0 valid

Top module: `blk_xlate_cache`

## Requirements
- R1: After reset every descriptor is cleared to zero (invalid), so every lookup reports a miss until a descriptor is loaded.
- R2: A descriptor whose valid bit (bit 0) is clear never matches.
- R3: A descriptor matches only when its supervisor-only bit (bit 2) equals `lk_super`. A user access never matches a supervisor entry, and a supervisor access never matches a user entry.
- R4: A descriptor matches when `lk_vaddr[31:19]` equals its bits [31:19]. Every offset inside the 512 KB block hits, and the neighbouring blocks miss.
- R5: On a hit, `lk_paddr` equals descriptor bits [18:6] placed at [31:19], with `lk_vaddr[18:0]` below them.
- R6: When the selected entry has write-protect (bit 1) set and `lk_write` is high, `lk_wfault` is raised. In that case `lk_hit` stays low and `lk_paddr` is zero.
- R7: On a hit, `lk_ro` is high exactly when the selected entry is write-protected.
- R8: When several entries match, the lowest-numbered one alone decides the result, including its write-protect bit.
- R9: A write with `cfg_wr_idx` equal to or above the entry count (10 to 15 by default) changes no entry. A write to a valid index takes effect from the next cycle.
- R10: For each valid request exactly one of `lk_hit`, `lk_miss` or `lk_wfault` is high in the same cycle. With `lk_valid` low, all three are low and `lk_paddr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Descriptor write strobe |
| cfg_wr_idx | input | 4 | Entry index for the write |
| cfg_wr_data | input | 32 | Descriptor value |
| lk_valid | input | 1 | Lookup request valid |
| lk_vaddr | input | 32 | Virtual address |
| lk_super | input | 1 | 1 = supervisor mode, 0 = user mode |
| lk_write | input | 1 | 1 = store access |
| lk_hit | output | 1 | Translation succeeded |
| lk_miss | output | 1 | No descriptor matched |
| lk_wfault | output | 1 | Write to a write-protected block |
| lk_ro | output | 1 | Hit block is read-only |
| lk_paddr | output | 32 | Translated physical address, zero unless hit |

## Verification
The assertions assume that the lookup inputs are stable while they are sampled at the clock edge. They also assume that a descriptor write and a lookup that depends on it do not fall in the same cycle, because a load only becomes visible one cycle after its write strobe. The stimulus follows both rules. It drives every input on the falling edge, waits a full cycle after each load, and reads the result in the low phase, once the combinational path has settled.

// File: rtl/batc_pkg.sv
package batc_pkg;
  localparam int unsigned VA_W   = 32;
  localparam int unsigned TAG_W  = 13;
  localparam int unsigned OFF_W  = VA_W - TAG_W;

  typedef struct packed {
    logic [TAG_W-1:0] vtag;
    logic [TAG_W-1:0] pblk;
    logic [2:0]       spare;
    logic             sup_only;
    logic             wprot;
    logic             vld;
  } desc_t;
endpackage

// File: rtl/batc_store.sv
module batc_store
  import batc_pkg::*;
#(
  parameter int unsigned ENTRIES = 10,
  parameter int unsigned IDX_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [VA_W-1:0]          wr_data,
  output desc_t [ENTRIES-1:0]      ent_o
);
  localparam logic [IDX_W:0] NENT = (IDX_W+1)'(ENTRIES);

  desc_t [ENTRIES-1:0] ent_q;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)
        ent_q[e] <= '0;
      else if (wr_en && wr_idx == IDX_W'(e))
        ent_q[e] <= desc_t'(wr_data);
    end
  end

  assign ent_o = ent_q;

  // R9: out-of-range index leaves every entry untouched
  a_r9_ignore_high: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && {1'b0, wr_idx} >= NENT) |=> $stable(ent_q));

  // R9: in-range write lands in the addressed entry
  a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && {1'b0, wr_idx} < NENT) |=> (ent_q[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/batc_match.sv
module batc_match
  import batc_pkg::*;
#(
  parameter int unsigned ENTRIES = 10
) (
  input  desc_t [ENTRIES-1:0] ent_i,
  input  logic [VA_W-1:0]     vaddr,
  input  logic                sup,
  output logic [ENTRIES-1:0]  match_o
);
  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign match_o[e] = ent_i[e].vld
                     && (ent_i[e].sup_only == sup)
                     && (ent_i[e].vtag == vaddr[VA_W-1:OFF_W]);
  end
endmodule

// File: rtl/batc_prio.sv
module batc_prio #(
  parameter int unsigned ENTRIES = 10,
  parameter int unsigned IDX_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ENTRIES-1:0]  req,
  output logic                any_o,
  output logic [IDX_W-1:0]    idx_o
);
  logic [ENTRIES-1:0] below;

  always_comb begin
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (req[i]) idx_o = IDX_W'(i);
  end

  assign any_o = |req;

  always_comb
    for (int i = 0; i < ENTRIES; i++)
      below[i] = (i < int'(idx_o));

  // R8: chosen entry matches and no lower entry does
  a_r8_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> (req[idx_o] && ((req & below) == '0)));
endmodule

// File: rtl/blk_xlate_cache.sv
module blk_xlate_cache
  import batc_pkg::*;
#(
  parameter int unsigned ENTRIES = 10,
  parameter int unsigned IDX_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [IDX_W-1:0] cfg_wr_idx,
  input  logic [31:0]      cfg_wr_data,
  input  logic             lk_valid,
  input  logic [31:0]      lk_vaddr,
  input  logic             lk_super,
  input  logic             lk_write,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic             lk_wfault,
  output logic             lk_ro,
  output logic [31:0]      lk_paddr
);
  desc_t [ENTRIES-1:0] ent;
  logic [ENTRIES-1:0]  match;
  logic                any;
  logic [IDX_W-1:0]    sel_idx;
  desc_t               sel;
  logic                blocked;

  batc_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_idx(cfg_wr_idx),
    .wr_data(cfg_wr_data), .ent_o(ent));

  batc_match #(.ENTRIES(ENTRIES)) u_match (
    .ent_i(ent), .vaddr(lk_vaddr), .sup(lk_super), .match_o(match));

  batc_prio #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_prio (
    .clk(clk), .rst_n(rst_n), .req(match), .any_o(any), .idx_o(sel_idx));

  assign sel       = ent[sel_idx];
  assign blocked   = sel.wprot && lk_write;
  assign lk_wfault = lk_valid && any && blocked;
  assign lk_hit    = lk_valid && any && !blocked;
  assign lk_miss   = lk_valid && !any;
  assign lk_ro     = lk_hit && sel.wprot;
  assign lk_paddr  = lk_hit ? {sel.pblk, lk_vaddr[OFF_W-1:0]} : '0;

  // R10: one outcome per valid request
  a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> ($countones({lk_hit, lk_miss, lk_wfault}) == 1));
  // R10: silent when idle
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !lk_miss && !lk_wfault && lk_paddr == '0));
  // R5: offset passes through
  a_r5_offset: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));
  // R6: fault only on stores
  a_r6_fault_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    lk_wfault |-> (lk_write && lk_paddr == '0));
  // R7: a successful store never reports read-only
  a_r7_store_rw: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_write) |-> !lk_ro);
endmodule

// File: tb/blk_xlate_cache_test.sv
module blk_xlate_cache_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [3:0]  cfg_wr_idx = '0;
  logic [31:0] cfg_wr_data = '0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_super = 1'b0;
  logic        lk_write = 1'b0;
  logic        lk_hit, lk_miss, lk_wfault, lk_ro;
  logic [31:0] lk_paddr;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  blk_xlate_cache uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx),
    .cfg_wr_data(cfg_wr_data), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_super(lk_super), .lk_write(lk_write), .lk_hit(lk_hit),
    .lk_miss(lk_miss), .lk_wfault(lk_wfault), .lk_ro(lk_ro), .lk_paddr(lk_paddr));

  function automatic logic [31:0] mk(logic [12:0] vt, logic [12:0] pb,
                                     logic so, logic wp, logic v);
    return {vt, pb, 3'b000, so, wp, v};
  endfunction

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(int idx, logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_idx = 4'(idx); cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic clear_all();
    for (int i = 0; i < 10; i++) wr(i, 32'h0);
  endtask

  task automatic lk(logic [31:0] va, logic sup, logic w);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; lk_super = sup; lk_write = w;
    #2;
  endtask

  task automatic expect_hit(string req, logic [31:0] pa, logic ro);
    chk(req, "hit", 32'(lk_hit), 32'd1);
    chk(req, "paddr", lk_paddr, pa);
    chk(req, "ro", 32'(lk_ro), 32'(ro));
  endtask

  task automatic expect_miss(string req);
    chk(req, "miss", 32'(lk_miss), 32'd1);
    chk(req, "hit", 32'(lk_hit), 32'd0);
  endtask

  task automatic t_reset();
    lk(32'h0000_0000, 1'b0, 1'b0); expect_miss("R1");
    lk(32'hFFFF_FFFC, 1'b1, 1'b1); expect_miss("R1");
  endtask

  task automatic t_basic();
    clear_all();
    wr(3, mk(13'h0A5, 13'h1F0, 1'b0, 1'b0, 1'b1));
    lk({13'h0A5, 19'h12345}, 1'b0, 1'b0); expect_hit("R5", {13'h1F0, 19'h12345}, 1'b0);
    lk({13'h0A5, 19'h00000}, 1'b0, 1'b1); expect_hit("R4", {13'h1F0, 19'h00000}, 1'b0);
    lk({13'h0A5, 19'h7FFFF}, 1'b0, 1'b0); expect_hit("R4", {13'h1F0, 19'h7FFFF}, 1'b0);
    lk({13'h0A6, 19'h00000}, 1'b0, 1'b0); expect_miss("R4");
    lk({13'h0A4, 19'h7FFFF}, 1'b0, 1'b0); expect_miss("R4");
  endtask

  task automatic t_valid();
    clear_all();
    wr(5, mk(13'h100, 13'h055, 1'b0, 1'b0, 1'b0));
    lk({13'h100, 19'h00010}, 1'b0, 1'b0); expect_miss("R2");
  endtask

  task automatic t_mode();
    clear_all();
    wr(1, mk(13'h200, 13'h0AA, 1'b1, 1'b0, 1'b1));
    wr(3, mk(13'h0A5, 13'h1F0, 1'b0, 1'b0, 1'b1));
    lk({13'h200, 19'h00400}, 1'b0, 1'b0); expect_miss("R3");
    lk({13'h200, 19'h00400}, 1'b1, 1'b0); expect_hit("R3", {13'h0AA, 19'h00400}, 1'b0);
    lk({13'h0A5, 19'h00400}, 1'b1, 1'b0); expect_miss("R3");
  endtask

  task automatic t_wprot();
    clear_all();
    wr(6, mk(13'h300, 13'h0C3, 1'b0, 1'b1, 1'b1));
    lk({13'h300, 19'h00ABC}, 1'b0, 1'b0); expect_hit("R7", {13'h0C3, 19'h00ABC}, 1'b1);
    lk({13'h300, 19'h00ABC}, 1'b0, 1'b1);
    chk("R6", "wfault", 32'(lk_wfault), 32'd1);
    chk("R6", "hit", 32'(lk_hit), 32'd0);
    chk("R6", "paddr", lk_paddr, 32'h0);
  endtask

  task automatic t_priority();
    clear_all();
    wr(7, mk(13'h400, 13'h222, 1'b0, 1'b0, 1'b1));
    wr(2, mk(13'h400, 13'h111, 1'b0, 1'b0, 1'b1));
    lk({13'h400, 19'h00008}, 1'b0, 1'b1); expect_hit("R8", {13'h111, 19'h00008}, 1'b0);
    wr(0, mk(13'h400, 13'h333, 1'b0, 1'b1, 1'b1));
    lk({13'h400, 19'h00008}, 1'b0, 1'b1);
    chk("R8", "wfault", 32'(lk_wfault), 32'd1);
    lk({13'h400, 19'h00008}, 1'b0, 1'b0); expect_hit("R8", {13'h333, 19'h00008}, 1'b1);
  endtask

  task automatic t_high_idx();
    clear_all();
    wr(4, mk(13'h0F0, 13'h0F1, 1'b0, 1'b0, 1'b1));
    for (int i = 10; i < 16; i++) wr(i, mk(13'h500, 13'h077, 1'b0, 1'b0, 1'b1));
    lk({13'h500, 19'h00020}, 1'b0, 1'b0); expect_miss("R9");
    lk({13'h0F0, 19'h00020}, 1'b0, 1'b0); expect_hit("R9", {13'h0F1, 19'h00020}, 1'b0);
    wr(9, mk(13'h501, 13'h078, 1'b0, 1'b0, 1'b1));
    lk({13'h501, 19'h00001}, 1'b0, 1'b0); expect_hit("R9", {13'h078, 19'h00001}, 1'b0);
  endtask

  task automatic t_idle();
    lk({13'h0F0, 19'h00020}, 1'b0, 1'b0);
    chk("R10", "strobes", 32'({lk_hit, lk_miss, lk_wfault}), 32'b100);
    @(negedge clk); lk_valid = 1'b0; #2;
    chk("R10", "idle strobes", 32'({lk_hit, lk_miss, lk_wfault}), 32'b000);
    chk("R10", "idle paddr", lk_paddr, 32'h0);
    lk({13'h7FF, 19'h00000}, 1'b0, 1'b0);
    chk("R10", "miss strobes", 32'({lk_hit, lk_miss, lk_wfault}), 32'b010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_valid();
    t_mode();
    t_wprot();
    t_priority();
    t_high_idx();
    t_idle();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule